// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor core that fetches, decodes and retires one instruction on every rising clock edge. It supports five register-to-register operations (add, subtract, AND, OR and signed set-less-than), a word load, a word store and a branch taken when two registers are equal. The core contains the program counter, the next-address adder, a 32 x 32 register file, the immediate sign extender, the ALU and its two decoding stages, and small word arrays for instructions and data.

The instruction decode works in two levels. A main decoder reads the 6-bit opcode and sets the per-class steering signals and a 2-bit operation class. A second decoder combines that class with the function field to choose the 3-bit ALU operation. Register file and memory reads are combinational. Every state element updates on the same rising edge.

A test environment loads both word arrays through dedicated load ports, usually while reset is held. It then reads register and data words back through debug ports. The instruction word uses the usual field layout: opcode [31:26], first source [25:21], second source or load target [20:16], destination [15:11], unused [10:6], function [5:0], and a 16-bit immediate in [15:0] for the immediate forms.

Top module: `sc_cpu_core`

## Requirements
- R1: A synchronous active-high reset clears the program counter and all 32 registers to zero on the next rising edge. Data memory is not cleared.
- R2: Opcode 0 with function 100000 (add), 100010 (subtract), 100100 (AND) or 100101 (OR) writes the result of that operation on the two source registers to the register named in bits [15:11].
- R3: Opcode 0 with function 101010 writes 1 to the destination when the first source is less than the second, compared as signed 32-bit values, and writes 0 otherwise.
- R4: Opcode 35 loads the data word at byte address (first source + sign-extended immediate) into the register named in bits [20:16]. The word index is taken from address bits [DAW+1:2], and the two low bits are ignored.
- R5: Opcode 43 stores the register named in bits [20:16] to the data word addressed as in R4 and writes no register.
- R6: Opcode 4 compares the two source registers. When they are equal, the next PC is PC+4 plus the sign-extended immediate shifted left by two. Otherwise the next PC is PC+4. It writes neither registers nor memory.
- R7: Register 0 always reads as zero, and any write to it is discarded.
- R8: Any opcode other than 0, 4, 35 and 43 writes neither registers nor data memory and advances the PC by 4.
- R9: Outside reset and taken branches, the PC advances by 4 each cycle. The instruction executed is the instruction word at index PC[IAW+1:2].
- R10: The debug ports return the selected register and data word combinationally. A data load-port write takes precedence over a store in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| im_ld_we | input | 1 | Instruction word load strobe |
| im_ld_addr | input | IAW | Instruction word index to load |
| im_ld_data | input | 32 | Instruction word to load |
| dm_ld_we | input | 1 | Data word load strobe |
| dm_ld_addr | input | DAW | Data word index to load |
| dm_ld_data | input | 32 | Data word to load |
| dbg_reg_sel | input | 5 | Register number to observe |
| dbg_reg_data | output | 32 | Contents of the selected register |
| dbg_mem_addr | input | DAW | Data word index to observe |
| dbg_mem_data | output | 32 | Contents of the selected data word |
| pc_out | output | 32 | Current program counter |

## Verification
The bound checker watches these properties on every cycle:
- the PC either steps by four or moves to the branch target;
- reset forces the PC to zero;
- register 0 reads as zero;
- set-less-than produces only 0 or 1;
- register-type and load instructions steer the write to the right destination field;
- branch, store and unknown opcodes keep the register write enable low, and branch and unknown opcodes also keep the memory write enable low.

The actual arithmetic results, signed-compare corner cases, the addressing of loads and stores (including negative offsets and ignored low address bits), backward branch loops, and the fact that reset clears the register file can only be shown by the bench's programs. The bench compares register and memory contents against values it computes itself.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

    localparam logic [5:0] OPC_RTYPE = 6'd0;
    localparam logic [5:0] OPC_BEQ   = 6'd4;
    localparam logic [5:0] OPC_LOAD  = 6'd35;
    localparam logic [5:0] OPC_STORE = 6'd43;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_SLT = 6'b101010;

    typedef enum logic [1:0] {
        AOP_ADD   = 2'b00,
        AOP_SUB   = 2'b01,
        AOP_FUNCT = 2'b10
    } aluop_e;

    typedef enum logic [2:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_ctl_e;

    typedef struct packed {
        logic   dst_rd;
        logic   reg_we;
        logic   src_imm;
        logic   branch;
        logic   mem_to_reg;
        logic   mem_rd;
        logic   mem_we;
        aluop_e aluop;
    } ctrl_t;

endpackage

// File: rtl/sc_main_dec.sv
module sc_main_dec
    import sc_core_pkg::*;
(
    input  logic [5:0] opc,
    output ctrl_t      ctrl
);

    always_comb begin
        ctrl = '{dst_rd: 1'b0, reg_we: 1'b0, src_imm: 1'b0, branch: 1'b0,
                 mem_to_reg: 1'b0, mem_rd: 1'b0, mem_we: 1'b0, aluop: AOP_ADD};
        case (opc)
            OPC_RTYPE: begin
                ctrl.dst_rd = 1'b1;
                ctrl.reg_we = 1'b1;
                ctrl.aluop  = AOP_FUNCT;
            end
            OPC_LOAD: begin
                ctrl.reg_we     = 1'b1;
                ctrl.src_imm    = 1'b1;
                ctrl.mem_to_reg = 1'b1;
                ctrl.mem_rd     = 1'b1;
            end
            OPC_STORE: begin
                ctrl.src_imm = 1'b1;
                ctrl.mem_we  = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.branch = 1'b1;
                ctrl.aluop  = AOP_SUB;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sc_alu_dec.sv
module sc_alu_dec
    import sc_core_pkg::*;
(
    input  aluop_e     aluop,
    input  logic [5:0] funct,
    output alu_ctl_e   ctl
);

    always_comb begin
        ctl = ALU_ADD;
        case (aluop)
            AOP_SUB: ctl = ALU_SUB;
            AOP_FUNCT: begin
                case (funct)
                    FN_SUB:  ctl = ALU_SUB;
                    FN_AND:  ctl = ALU_AND;
                    FN_OR:   ctl = ALU_OR;
                    FN_SLT:  ctl = ALU_SLT;
                    default: ctl = ALU_ADD;
                endcase
            end
            default: ctl = ALU_ADD;
        endcase
    end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_core_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_ctl_e     ctl,
    output logic [W-1:0] y,
    output logic         zero
);

    logic         b_inv;
    logic [W-1:0] b_sel;
    logic [W-1:0] sum;
    logic         lt;

    always_comb begin
        // subtract and compare share the adder: inverted operand plus carry-in
        b_inv = ctl[2];
        b_sel = b_inv ? ~b : b;
        sum   = a + b_sel + {{(W-1){1'b0}}, b_inv};
        lt    = (a[W-1] ^ b[W-1]) ? a[W-1] : sum[W-1];
        case (ctl)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(W-1){1'b0}}, lt};
            default: y = sum;
        endcase
        zero = (y == '0);
    end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int W    = 32,
    parameter int NREG = 32,
    parameter int RAW  = $clog2(NREG)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           we,
    input  logic [RAW-1:0] waddr,
    input  logic [W-1:0]   wdata,
    input  logic [RAW-1:0] ra_a,
    input  logic [RAW-1:0] ra_b,
    input  logic [RAW-1:0] ra_dbg,
    output logic [W-1:0]   rd_a,
    output logic [W-1:0]   rd_b,
    output logic [W-1:0]   rd_dbg
);

    logic [W-1:0] regs_d [NREG];
    logic [W-1:0] regs_q [NREG];

    always_comb begin
        regs_d = regs_q;
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs_d[i] = '0;
        end else if (we) begin
            regs_d[waddr] = wdata;
        end
        regs_d[0] = '0;
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign rd_a   = regs_q[ra_a];
    assign rd_b   = regs_q[ra_b];
    assign rd_dbg = regs_q[ra_dbg];

endmodule

// File: rtl/sc_cpu_core.sv
module sc_cpu_core
    import sc_core_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    parameter int IAW        = $clog2(IMEM_WORDS),
    parameter int DAW        = $clog2(DMEM_WORDS)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           im_ld_we,
    input  logic [IAW-1:0] im_ld_addr,
    input  logic [31:0]    im_ld_data,
    input  logic           dm_ld_we,
    input  logic [DAW-1:0] dm_ld_addr,
    input  logic [31:0]    dm_ld_data,
    input  logic [4:0]     dbg_reg_sel,
    output logic [31:0]    dbg_reg_data,
    input  logic [DAW-1:0] dbg_mem_addr,
    output logic [31:0]    dbg_mem_data,
    output logic [31:0]    pc_out
);

    localparam int XLEN = 32;

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } core_st_t;

    core_st_t        st_d, st_q;
    logic [XLEN-1:0] imem_d [IMEM_WORDS];
    logic [XLEN-1:0] imem_q [IMEM_WORDS];
    logic [XLEN-1:0] dmem_d [DMEM_WORDS];
    logic [XLEN-1:0] dmem_q [DMEM_WORDS];

    logic [XLEN-1:0] instr;
    logic [5:0]      opc, funct;
    logic [4:0]      rs, rt, rd, rf_waddr;
    logic [15:0]     imm;
    ctrl_t           ctrl;
    alu_ctl_e        alu_ctl;
    logic [XLEN-1:0] rd_a, rd_b, imm_ext, alu_b, alu_y, dm_rdata, wb_data;
    logic [XLEN-1:0] pc_plus4, br_tgt;
    logic [DAW-1:0]  dm_idx;
    logic            zero, take_br;
    logic            unused_bits;

    // fetch and field split
    assign instr   = imem_q[st_q.pc[IAW+1:2]];
    assign opc     = instr[31:26];
    assign rs      = instr[25:21];
    assign rt      = instr[20:16];
    assign rd      = instr[15:11];
    assign funct   = instr[5:0];
    assign imm     = instr[15:0];
    assign imm_ext = {{(XLEN-16){imm[15]}}, imm};
    assign unused_bits = ^{instr[10:6], imm_ext[XLEN-1:XLEN-2]};

    sc_main_dec u_mdec (
        .opc  (opc),
        .ctrl (ctrl)
    );

    sc_alu_dec u_adec (
        .aluop (ctrl.aluop),
        .funct (funct),
        .ctl   (alu_ctl)
    );

    sc_regfile #(.W(XLEN), .NREG(32)) u_rf (
        .clk    (clk),
        .rst    (rst),
        .we     (ctrl.reg_we),
        .waddr  (rf_waddr),
        .wdata  (wb_data),
        .ra_a   (rs),
        .ra_b   (rt),
        .ra_dbg (dbg_reg_sel),
        .rd_a   (rd_a),
        .rd_b   (rd_b),
        .rd_dbg (dbg_reg_data)
    );

    assign alu_b = ctrl.src_imm ? imm_ext : rd_b;

    sc_alu #(.W(XLEN)) u_alu (
        .a    (rd_a),
        .b    (alu_b),
        .ctl  (alu_ctl),
        .y    (alu_y),
        .zero (zero)
    );

    assign dm_idx   = alu_y[DAW+1:2];
    assign dm_rdata = ctrl.mem_rd ? dmem_q[dm_idx] : '0;
    assign wb_data  = ctrl.mem_to_reg ? dm_rdata : alu_y;
    assign rf_waddr = ctrl.dst_rd ? rd : rt;
    assign take_br  = ctrl.branch & zero;
    assign pc_plus4 = st_q.pc + XLEN'(4);
    assign br_tgt   = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};

    always_comb begin
        st_d = st_q;
        if (rst)          st_d.pc = '0;
        else if (take_br) st_d.pc = br_tgt;
        else              st_d.pc = pc_plus4;

        imem_d = imem_q;
        if (im_ld_we) imem_d[im_ld_addr] = im_ld_data;

        dmem_d = dmem_q;
        if (dm_ld_we)                 dmem_d[dm_ld_addr] = dm_ld_data;
        else if (ctrl.mem_we && !rst) dmem_d[dm_idx]     = rd_b;
    end

    always_ff @(posedge clk) begin
        st_q   <= st_d;
        imem_q <= imem_d;
        dmem_q <= dmem_d;
    end

    assign dbg_mem_data = dmem_q[dbg_mem_addr];
    assign pc_out       = st_q.pc;

endmodule

// File: rtl/sc_cpu_checker.sv
module sc_cpu_checker (
    input logic        clk,
    input logic        rst,
    input logic [31:0] pc,
    input logic [31:0] instr,
    input logic        rf_we,
    input logic [4:0]  rf_waddr,
    input logic        dm_we,
    input logic        take_br,
    input logic [2:0]  alu_ctl,
    input logic [31:0] alu_y,
    input logic [4:0]  dbg_reg_sel,
    input logic [31:0] dbg_reg_data
);

    logic [5:0] opc;
    logic       known;
    assign opc   = instr[31:26];
    assign known = (opc == 6'd0) || (opc == 6'd4) || (opc == 6'd35) || (opc == 6'd43);

    a_r1_reset_pc: assert property (@(posedge clk) rst |=> pc == 32'd0);

    a_r9_seq_pc: assert property (@(posedge clk) disable iff (rst)
        !take_br |=> pc == $past(pc) + 32'd4);

    a_r6_branch_pc: assert property (@(posedge clk) disable iff (rst)
        take_br |=> pc == $past(pc) + 32'd4 +
                   {{14{$past(instr[15])}}, $past(instr[15:0]), 2'b00});

    a_r6_branch_quiet: assert property (@(posedge clk) disable iff (rst)
        (opc == 6'd4) |-> (!rf_we && !dm_we));

    a_r5_store_no_reg: assert property (@(posedge clk) disable iff (rst)
        (opc == 6'd43) |-> (!rf_we && dm_we));

    a_r8_unknown_quiet: assert property (@(posedge clk) disable iff (rst)
        !known |-> (!rf_we && !dm_we && !take_br));

    a_r2_rtype_dest: assert property (@(posedge clk) disable iff (rst)
        (opc == 6'd0) |-> (rf_we && rf_waddr == instr[15:11]));

    a_r4_load_dest: assert property (@(posedge clk) disable iff (rst)
        (opc == 6'd35) |-> (rf_we && rf_waddr == instr[20:16]));

    a_r3_slt_bool: assert property (@(posedge clk) disable iff (rst)
        (alu_ctl == 3'b111) |-> (alu_y[31:1] == 31'd0));

    a_r7_zero_reg: assert property (@(posedge clk) disable iff (rst)
        (dbg_reg_sel == 5'd0) |-> (dbg_reg_data == 32'd0));

endmodule

bind sc_cpu_core sc_cpu_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .pc           (st_q.pc),
    .instr        (instr),
    .rf_we        (ctrl.reg_we),
    .rf_waddr     (rf_waddr),
    .dm_we        (ctrl.mem_we),
    .take_br      (take_br),
    .alu_ctl      (alu_ctl),
    .alu_y        (alu_y),
    .dbg_reg_sel  (dbg_reg_sel),
    .dbg_reg_data (dbg_reg_data)
);

// File: tb/tb_sc_cpu_core.sv
module tb_sc_cpu_core;

    localparam int CLK_PERIOD = 10;
    localparam int IW  = 64;
    localparam int DW  = 64;
    localparam int IAW = 6;
    localparam int DAW = 6;
    localparam int WD_CYCLES = 150000;
    localparam logic [31:0] NOP  = 32'h0800_0000;   // opcode 2: unsupported
    localparam logic [31:0] HALT = {6'd4, 5'd0, 5'd0, 16'hFFFF};

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           im_ld_we = 1'b0;
    logic [IAW-1:0] im_ld_addr = '0;
    logic [31:0]    im_ld_data = '0;
    logic           dm_ld_we = 1'b0;
    logic [DAW-1:0] dm_ld_addr = '0;
    logic [31:0]    dm_ld_data = '0;
    logic [4:0]     dbg_reg_sel = '0;
    logic [31:0]    dbg_reg_data;
    logic [DAW-1:0] dbg_mem_addr = '0;
    logic [31:0]    dbg_mem_data;
    logic [31:0]    pc_out;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] prog [IW];
    logic [31:0] vals [8];
    logic [5:0]  fns  [5];
    logic [31:0] v;

    always #(CLK_PERIOD/2) clk = ~clk;

    sc_cpu_core #(.IMEM_WORDS(IW), .DMEM_WORDS(DW)) dut (
        .clk(clk), .rst(rst),
        .im_ld_we(im_ld_we), .im_ld_addr(im_ld_addr), .im_ld_data(im_ld_data),
        .dm_ld_we(dm_ld_we), .dm_ld_addr(dm_ld_addr), .dm_ld_data(dm_ld_data),
        .dbg_reg_sel(dbg_reg_sel), .dbg_reg_data(dbg_reg_data),
        .dbg_mem_addr(dbg_mem_addr), .dbg_mem_data(dbg_mem_data),
        .pc_out(pc_out)
    );

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(int op, int rs, int rt, logic [15:0] imm);
        return {6'(op), 5'(rs), 5'(rt), imm};
    endfunction

    function automatic logic [31:0] model_alu(int op, logic [31:0] a, logic [31:0] b);
        case (op)
            0: return a + b;
            1: return a - b;
            2: return a & b;
            3: return a | b;
            default: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic prog_clear();
        for (int w = 0; w < IW; w++) prog[w] = NOP;
    endtask

    task automatic load_prog();
        @(negedge clk);
        rst = 1'b1;
        for (int w = 0; w < IW; w++) begin
            @(negedge clk);
            im_ld_we = 1'b1; im_ld_addr = IAW'(w); im_ld_data = prog[w];
        end
        @(negedge clk);
        im_ld_we = 1'b0;
    endtask

    task automatic dm_load(int a, logic [31:0] d);
        @(negedge clk);
        dm_ld_we = 1'b1; dm_ld_addr = DAW'(a); dm_ld_data = d;
        @(negedge clk);
        dm_ld_we = 1'b0;
    endtask

    task automatic get_reg(int r, output logic [31:0] val);
        dbg_reg_sel = 5'(r);
        #1;
        val = dbg_reg_data;
    endtask

    task automatic get_mem(int a, output logic [31:0] val);
        dbg_mem_addr = DAW'(a);
        #1;
        val = dbg_mem_data;
    endtask

    task automatic start();
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001;
        vals[2] = 32'hFFFF_FFFF; vals[3] = 32'h7FFF_FFFF;
        vals[4] = 32'h8000_0000; vals[5] = 32'h0000_0005;
        vals[6] = 32'hFFFF_FFF9; vals[7] = 32'h1234_5678;
        fns[0] = 6'b100000; fns[1] = 6'b100010; fns[2] = 6'b100100;
        fns[3] = 6'b100101; fns[4] = 6'b101010;

        repeat (2) @(negedge clk);
        for (int i = 0; i < 8; i++) dm_load(i, vals[i]);
        dm_load(12, 32'd100);
        dm_load(30, 32'd5);
        dm_load(31, 32'd5);
        dm_load(32, 32'd9);
        check("R1 pc held at zero in reset", pc_out, 32'd0);

        // R2 / R3 sweep: every operation over every operand pair
        for (int op = 0; op < 5; op++) begin
            for (int a = 0; a < 8; a++) begin
                prog_clear();
                for (int i = 0; i < 8; i++) prog[i] = enc_i(35, 0, i + 1, 16'(4 * i));
                for (int b = 0; b < 8; b++) prog[8 + b] = enc_r(a + 1, b + 1, 9 + b, fns[op]);
                prog[16] = HALT;
                load_prog();
                start();
                repeat (18) @(negedge clk);
                for (int b = 0; b < 8; b++) begin
                    get_reg(9 + b, v);
                    check(op == 4 ? "R3 signed compare" : "R2 register op",
                          v, model_alu(op, vals[a], vals[b]));
                end
                if (op == 0) begin
                    get_reg(a + 1, v);
                    check("R4 load word", v, vals[a]);
                end
                if (op == 0 && a == 0) check("R6 halt self-loop", pc_out, 32'd64);
            end
        end

        // R1: reset clears all registers and the PC
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        for (int r = 0; r < 32; r++) begin
            get_reg(r, v);
            check("R1 register cleared", v, 32'd0);
        end
        check("R1 pc cleared", pc_out, 32'd0);

        // R4 / R5: addressing, ignored low bits, negative offset
        prog_clear();
        prog[0] = enc_i(35, 0, 1, 16'd12);
        prog[1] = enc_i(35, 0, 2, 16'd50);
        prog[2] = enc_i(43, 0, 1, 16'd42);
        prog[3] = enc_i(43, 2, 1, 16'hFFF8);
        prog[4] = enc_i(35, 0, 3, 16'd40);
        prog[5] = HALT;
        load_prog();
        start();
        repeat (7) @(negedge clk);
        get_reg(1, v); check("R4 load aligned", v, vals[3]);
        get_reg(2, v); check("R4 load low bits ignored", v, 32'd100);
        get_mem(10, v); check("R5 store low bits ignored", v, vals[3]);
        get_mem(23, v); check("R5 store negative offset", v, vals[3]);
        get_reg(3, v); check("R4 load after store", v, vals[3]);
        get_reg(4, v); check("R5 no register written", v, 32'd0);

        // R6: not-taken, forward-taken and backward-taken branches
        prog_clear();
        prog[0] = enc_i(35, 0, 1, 16'd120);
        prog[1] = enc_i(35, 0, 2, 16'd124);
        prog[2] = enc_i(35, 0, 3, 16'd128);
        prog[3] = enc_i(4, 1, 3, 16'd1);
        prog[4] = enc_i(4, 1, 2, 16'd2);
        prog[5] = enc_i(35, 0, 4, 16'd120);
        prog[6] = enc_i(35, 0, 4, 16'd120);
        prog[7] = enc_i(4, 2, 1, 16'hFFFB);
        load_prog();
        start();
        begin
            logic [31:0] exp_pc [8];
            exp_pc = '{32'd4, 32'd8, 32'd12, 32'd16, 32'd28, 32'd12, 32'd16, 32'd28};
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                check("R6 branch pc trace", pc_out, exp_pc[k]);
            end
        end
        get_reg(4, v); check("R6 skipped instructions", v, 32'd0);

        // R7 / R8 / R9: zero register, unsupported opcodes, sequential PC
        prog_clear();
        prog[0] = enc_i(35, 0, 1, 16'd120);
        prog[1] = enc_r(1, 1, 0, 6'b100000);
        prog[2] = enc_i(35, 0, 0, 16'd120);
        prog[3] = enc_i(8, 1, 5, 16'd7);
        prog[4] = NOP;
        prog[5] = enc_i(15, 0, 6, 16'hFFFF);
        prog[6] = enc_i(41, 0, 1, 16'd128);
        prog[7] = HALT;
        load_prog();
        start();
        for (int k = 1; k <= 9; k++) begin
            @(negedge clk);
            check("R9 sequential pc", pc_out, (k <= 7) ? 32'(4 * k) : 32'd28);
        end
        get_reg(0, v); check("R7 zero register", v, 32'd0);
        get_reg(1, v); check("R4 load source", v, 32'd5);
        get_reg(5, v); check("R8 unknown opcode no write", v, 32'd0);
        get_reg(6, v); check("R8 unknown opcode no write", v, 32'd0);
        get_mem(32, v); check("R8 unknown opcode no store", v, 32'd9);

        // R10: load port wins over a store in the same cycle
        prog_clear();
        prog[0] = enc_i(35, 0, 1, 16'd120);
        prog[1] = enc_i(43, 0, 1, 16'd160);
        prog[2] = HALT;
        load_prog();
        start();
        dm_ld_we = 1'b1; dm_ld_addr = DAW'(40); dm_ld_data = 32'hCAFE_0001;
        repeat (2) @(negedge clk);
        dm_ld_we = 1'b0;
        @(negedge clk);
        get_mem(40, v); check("R10 load port priority", v, 32'hCAFE_0001);

        finish_run();
    end

endmodule